// File: doc/BRIEF.md
# DS2 Alarm Indication Signal Detector

This block watches a serial DS2 bit stream for the alarm indication signal, the all-ones pattern that an upstream node sends in place of traffic after a failure. Bits arrive on a data line and count only in cycles where a bit-enable input is high. The stream is cut into back-to-back, non-overlapping windows of 840 qualified bits. In each window the block counts zeros, and the count stops rising at five because only the threshold matters.

The status output uses hysteresis across windows. The alarm is raised after two consecutive windows that each carry fewer than five zeros. It is dropped after two consecutive windows that each carry five or more zeros. A window that breaks the pattern for the current direction starts the run count again. The status moves only at a window boundary. An idle input parks the detector: the status is held low and the window, the zero count and the run count all restart.

Top module: `ds2_alarm_watch`

## Requirements
- R1: After reset the alarm output `ais_flag` is 0 and the first window starts at the first qualified bit.
- R2: A window is exactly 840 qualified bits, meaning bits taken while `bit_en` = 1. Cycles with `bit_en` = 0 neither advance the window nor add zeros, whatever `bit_in` carries.
- R3: While the alarm is low, two consecutive windows that each hold 0 to 4 zeros set `ais_flag` to 1. The output changes on the clock edge that takes the last bit of the second window.
- R4: One qualifying window is not enough. A window that does not meet the condition for the current direction discards the earlier qualifying window, so two new consecutive qualifying windows are needed.
- R5: While the alarm is high, two consecutive windows that each hold 5 or more zeros clear `ais_flag` to 0. The output changes on the edge that takes the last bit of the second window.
- R6: `ais_flag` changes only on the edge that takes the last bit of a window, or because of the idle input.
- R7: While `idle_mode` = 1, `ais_flag` is 0 from the next edge onward. Idle clears the run count and the zero count, and the first qualified bit after idle starts a new window.
- R8: Threshold boundary: a window with exactly 4 zeros counts toward declaring the alarm, and a window with exactly 5 zeros counts toward clearing it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | High when `bit_in` carries a valid DS2 bit this cycle |
| bit_in | input | 1 | Serial DS2 data bit |
| idle_mode | input | 1 | High parks the detector and holds the status low |
| ais_flag | output | 1 | Alarm indication signal status, 1 when declared |

## Verification
The hardest case to reach from the ports is a window boundary that lands exactly where the zero-count threshold and the run count meet. The run may be broken by a window one zero off the threshold, and gaps in `bit_en` shift where the boundary falls in time. The stimulus sweeps the zeros per window from 0 to 6 in both directions. It interleaves qualifying and non-qualifying windows, and it inserts disabled cycles that carry zeros. A reference model in the bench, updated once per window, gives the expected status. The output is also sampled one bit before each boundary and halfway through each window, to confirm that the status does not move early.

// File: rtl/ds2aw_pkg.sv
package ds2aw_pkg;

  // Alarm status held by the verdict stage
  typedef enum logic {
    AW_QUIET = 1'b0,
    AW_ALARM = 1'b1
  } aw_state_t;

endpackage

// File: rtl/ds2aw_rst_sync.sv
module ds2aw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;

endmodule

// File: rtl/ds2aw_window_timer.sv
module ds2aw_window_timer #(
  parameter int WIN_LEN = 840
) (
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  input  logic bit_en,
  output logic win_last
);

  localparam int POS_W = $clog2(WIN_LEN);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(WIN_LEN - 1);

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_d;

  always_comb begin
    win_last = bit_en && !idle && (pos_q == LAST_POS);
    pos_d    = pos_q;
    if (idle) begin
      pos_d = '0;
    end else if (bit_en) begin
      if (win_last) pos_d = '0;
      else          pos_d = pos_q + POS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  // R2: the bit position never leaves the window
  assert_pos_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= LAST_POS);

  // R2: a disabled cycle leaves the position untouched
  assert_pos_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !idle) |=> $stable(pos_q));

  // R7: idle restarts the window
  assert_idle_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> (pos_q == '0));

endmodule

// File: rtl/ds2aw_zero_tally.sv
module ds2aw_zero_tally #(
  parameter int ZERO_LIMIT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  input  logic bit_en,
  input  logic bit_in,
  input  logic win_last,
  output logic few_zeros
);

  localparam int TW = $clog2(ZERO_LIMIT + 1);
  localparam logic [TW-1:0] SAT = TW'(ZERO_LIMIT);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic [TW-1:0] cnt_with;
  logic          zero_seen;

  always_comb begin
    zero_seen = bit_en && !bit_in;
    cnt_with  = cnt_q;
    if (zero_seen && (cnt_q != SAT)) cnt_with = cnt_q + TW'(1);
    few_zeros = (cnt_with < SAT);
    if (idle || win_last) cnt_d = '0;
    else                  cnt_d = cnt_with;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R8: the tally saturates at the threshold
  assert_tally_saturates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= SAT);

  // R2: a disabled cycle adds no zero
  assert_disabled_no_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !idle) |=> $stable(cnt_q));

  // R7: idle clears the tally
  assert_idle_clears_tally_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> (cnt_q == '0));

endmodule

// File: rtl/ds2aw_verdict.sv
module ds2aw_verdict
  import ds2aw_pkg::*;
#(
  parameter int RUN_NEED = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  input  logic win_last,
  input  logic few_zeros,
  output logic alarm
);

  localparam int RUN_W = $clog2(RUN_NEED + 1);
  localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(RUN_NEED - 1);

  aw_state_t       state_q, state_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic             agree;

  always_comb begin
    agree   = (state_q == AW_QUIET) ? few_zeros : !few_zeros;
    state_d = state_q;
    run_d   = run_q;
    if (idle) begin
      state_d = AW_QUIET;
      run_d   = '0;
    end else if (win_last) begin
      if (!agree) begin
        run_d = '0;
      end else if (run_q == RUN_TOP) begin
        state_d = (state_q == AW_QUIET) ? AW_ALARM : AW_QUIET;
        run_d   = '0;
      end else begin
        run_d = run_q + RUN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= AW_QUIET;
      run_q   <= '0;
    end else begin
      state_q <= state_d;
      run_q   <= run_d;
    end
  end

  assign alarm = (state_q == AW_ALARM);

  // R4: the run count stays below the required length
  assert_run_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_TOP);

  // R3: the alarm rises only at the end of a window with few zeros
  assert_rise_on_quiet_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> $past(win_last && few_zeros && !idle));

  // R5: the alarm falls only at a window with many zeros, or through idle
  assert_fall_on_busy_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alarm) |-> $past(idle || (win_last && !few_zeros)));

  // R6: no status change away from a boundary
  assert_change_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm != $past(alarm)) |-> $past(win_last || idle));

  // R7: idle forces the status low
  assert_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> !alarm);

endmodule

// File: rtl/ds2_alarm_watch.sv
module ds2_alarm_watch #(
  parameter int WIN_LEN    = 840,
  parameter int ZERO_LIMIT = 5,
  parameter int RUN_NEED   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bit_in,
  input  logic idle_mode,
  output logic ais_flag
);

  logic rst_sync_n;
  logic win_last;
  logic few_zeros;

  ds2aw_rst_sync i_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  ds2aw_window_timer #(.WIN_LEN(WIN_LEN)) i_window_timer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .idle    (idle_mode),
    .bit_en  (bit_en),
    .win_last(win_last)
  );

  ds2aw_zero_tally #(.ZERO_LIMIT(ZERO_LIMIT)) i_zero_tally (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .idle     (idle_mode),
    .bit_en   (bit_en),
    .bit_in   (bit_in),
    .win_last (win_last),
    .few_zeros(few_zeros)
  );

  ds2aw_verdict #(.RUN_NEED(RUN_NEED)) i_verdict (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .idle     (idle_mode),
    .win_last (win_last),
    .few_zeros(few_zeros),
    .alarm    (ais_flag)
  );

  // R1: the status is low while reset is applied
  assert_reset_low_R1: assert property (@(posedge clk)
    !rst_sync_n |-> !ais_flag);

endmodule

// File: tb/test_ds2_alarm_watch.sv
`timescale 1ns/1ps
module test_ds2_alarm_watch;

  localparam int WIN = 840;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0;
  logic bit_in = 1'b1;
  logic idle_mode = 1'b0;
  logic ais_flag;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // bench reference model, updated once per window
  bit exp_alarm = 1'b0;
  int exp_run = 0;

  always #10 clk = ~clk;

  ds2_alarm_watch i_ds2_alarm_watch (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .bit_in   (bit_in),
    .idle_mode(idle_mode),
    .ais_flag (ais_flag)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: ais_flag actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive one cycle from a falling edge to the next falling edge
  task automatic put_bit(input logic b, input logic en);
    bit_in = b;
    bit_en = en;
    @(negedge clk);
  endtask

  task automatic model_window(input int zeros);
    bit few = (zeros < 5);
    bit agree = exp_alarm ? !few : few;
    if (!agree) exp_run = 0;
    else if (exp_run == 1) begin exp_alarm = !exp_alarm; exp_run = 0; end
    else exp_run = exp_run + 1;
  endtask

  task automatic go_idle(input int cycles);
    idle_mode = 1'b1;
    for (int k = 0; k < cycles; k++) put_bit(1'b1, 1'b0);
    idle_mode = 1'b0;
    exp_alarm = 1'b0;
    exp_run = 0;
    check("R7 idle low", ais_flag, 0);
  endtask

  // one window with a given number of zeros; gaps add disabled zero cycles
  task automatic send_window(input int zeros, input bit gaps, input string tag);
    for (int i = 0; i < WIN; i++) begin
      if (gaps && (i % 50 == 25)) put_bit(1'b0, 1'b0);
      put_bit(((i % 160 == 7) && (i / 160 < zeros)) ? 1'b0 : 1'b1, 1'b1);
      if (i == WIN / 2) check("R6 mid-window", ais_flag, int'(exp_alarm));
      if (i == WIN - 2) check("R6 before boundary", ais_flag, int'(exp_alarm));
    end
    model_window(zeros);
    check(tag, ais_flag, int'(exp_alarm));
  endtask

  initial begin
    #(20ns * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 during reset", ais_flag, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after reset", ais_flag, 0);

    // R1/R2: first window starts at first qualified bit after reset
    send_window(0, 1'b0, "R1 first window no declare");
    send_window(0, 1'b0, "R3 declare after two quiet windows");

    // declare sweep over zeros per window, R3/R4/R8
    for (int z = 0; z <= 6; z++) begin
      go_idle(3);
      send_window(z, z[0], "R4 one window not enough");
      if (z == 4)      send_window(z, 1'b0, "R8 four zeros declares");
      else if (z == 5) send_window(z, 1'b0, "R8 five zeros no declare");
      else             send_window(z, z[0], "R3 declare sweep");
    end

    // clear sweep from the alarm state, R5/R8
    for (int c = 0; c <= 6; c++) begin
      go_idle(2);
      send_window(0, 1'b0, "R3 arm");
      send_window(0, 1'b0, "R3 arm");
      send_window(c, c[0], "R5 one busy window keeps alarm");
      if (c == 4)      send_window(c, 1'b0, "R8 four zeros keeps alarm");
      else if (c == 5) send_window(c, 1'b0, "R8 five zeros clears");
      else             send_window(c, c[0], "R5 clear sweep");
    end

    // broken runs, R4
    go_idle(2);
    send_window(0, 1'b0, "R4 quiet run start");
    send_window(6, 1'b0, "R4 run broken");
    send_window(0, 1'b0, "R4 restarted run");
    send_window(0, 1'b0, "R3 declare after restart");
    send_window(6, 1'b0, "R5 busy run start");
    send_window(2, 1'b0, "R4 busy run broken");
    send_window(6, 1'b0, "R4 busy run restarted");
    send_window(6, 1'b0, "R5 clear after restart");

    // R2: disabled cycles carrying zeros are not counted
    go_idle(2);
    send_window(4, 1'b1, "R2 gaps ignored first");
    send_window(4, 1'b1, "R2 gaps ignored declare");

    // R2/R6: exact window length
    go_idle(2);
    send_window(0, 1'b0, "R2 run one");
    for (int i = 0; i < WIN - 1; i++) put_bit(1'b1, 1'b1);
    check("R2 839 bits no change", ais_flag, 0);
    put_bit(1'b1, 1'b0);
    check("R2 disabled bit no boundary", ais_flag, 0);
    put_bit(1'b1, 1'b1);
    check("R2 840th bit declares", ais_flag, 1);
    exp_alarm = 1'b1;
    exp_run = 0;

    // R7: idle during alarm and mid-window restart
    put_bit(1'b1, 1'b1);
    idle_mode = 1'b1;
    put_bit(1'b1, 1'b1);
    check("R7 idle drops alarm", ais_flag, 0);
    idle_mode = 1'b0;
    for (int i = 0; i < 500; i++) put_bit(1'b1, 1'b1);
    go_idle(1);
    for (int i = 0; i < 2 * WIN - 1; i++) put_bit(1'b1, 1'b1);
    check("R7 restart not early", ais_flag, 0);
    put_bit(1'b1, 1'b1);
    check("R7 restart window aligned", ais_flag, 1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule